// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches the live calendar fields of a real-time clock and raises an alarm when they agree with a stored alarm setting. It holds two independent alarm sets. Each set has one byte for each of six compared fields: seconds, minutes, hours, date, month and day-of-week. A stored byte uses the same bit layout as the matching clock byte, except that its top bit is an active-high enable. Only the enabled fields take part in the comparison. A disabled field always counts as agreeing. An alarm set with no enabled field never fires. There is no year byte, and the year is never compared.

The timekeeping logic pulses `tick_i` once each time the clock advances. On that strobe each set evaluates its match. The set's sticky flag rises only when the match goes from false to true. A match that stays true over several strobes therefore fires once. Software loads the alarm bytes through a simple write port and clears a flag by pulsing that set's bit of the clear input.

Top module: `cal_alarm_cmp`

## Requirements
- R1: While rst_ni is low, and after it is released, alarm_flag_o and alarm_pulse_o are 0, and every alarm byte is 0, so every field is disabled.
- R2: A cycle with wr_en_i high stores wr_data_i into the byte of set wr_alarm_i that wr_field_i selects. The field codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week. Codes 6 and 7 change nothing.
- R3: An enabled field compares its bits 6:0 with bits 6:0 of the matching rtc_fields_i byte. Field k sits at rtc_fields_i[8k+7:8k]. Bit 7 of the clock byte is ignored.
- R4: A field whose enable bit (bit 7 of the alarm byte) is 0 counts as matching for any clock value. Any subset of fields, up to all six, may be enabled.
- R5: A set with no enable bit set never fires, whatever the clock value.
- R6: The match is evaluated only in cycles with tick_i high. A flag can rise only in the cycle after such a tick.
- R7: A flag is set, and its pulse raised, only when the match is true on a tick and was false on the previous tick for that set. A match that persists across ticks does not fire again, even after the flag is cleared.
- R8: A set flag stays high until its bit of flag_clr_i is high for a cycle. When a new fire and a clear occur in the same cycle, the flag ends up set.
- R9: The two sets are evaluated, flagged and cleared independently of each other.
- R10: alarm_pulse_o[a] is high for exactly the one cycle in which alarm_flag_o[a] rises. It is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Alarm byte write strobe |
| wr_alarm_i | input | ALM_W (1) | Alarm set selected for the write |
| wr_field_i | input | FLD_W (3) | Field code selected for the write |
| wr_data_i | input | FIELD_W (8) | Byte to store, with the enable in bit 7 |
| rtc_fields_i | input | NUM_FIELDS*FIELD_W (48) | Live clock fields, seconds in the lowest byte |
| tick_i | input | 1 | One-cycle strobe marking a clock advance |
| flag_clr_i | input | NUM_ALARMS (2) | Clear for each set's flag |
| alarm_flag_o | output | NUM_ALARMS (2) | Sticky alarm flags |
| alarm_pulse_o | output | NUM_ALARMS (2) | One-cycle fire indication |

## Verification
The bench uses the defaults: two alarm sets, six fields of eight bits, and a three-bit field code. The three-bit code makes the unused codes 6 and 7 reachable, so a write decoder that drops the top bit would show up as a spurious enable. With two sets, one set can hold a seconds-only alarm while the other holds a full six-field alarm. This shows both the once-per-minute firing pattern and the independence of the sets. A persistent match and a fire that coincides with a clear are also driven.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam int NUM_ALARMS = 2;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_reg_bank.sv
module alarm_reg_bank #(
  parameter int NUM_FIELDS = cal_alarm_pkg::NUM_FIELDS,
  parameter int FIELD_W    = cal_alarm_pkg::FIELD_W,
  parameter int IDX_W      = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [FIELD_W-1:0]            wr_data_i,
  output logic [NUM_FIELDS*FIELD_W-1:0] bytes_o
);
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    logic [FIELD_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        byte_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(k)))
        byte_q <= wr_data_i;
    end
    assign bytes_o[k*FIELD_W +: FIELD_W] = byte_q;
  end
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int NUM_FIELDS = cal_alarm_pkg::NUM_FIELDS,
  parameter int FIELD_W    = cal_alarm_pkg::FIELD_W
) (
  input  logic [NUM_FIELDS*FIELD_W-1:0] alm_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] rtc_i,
  output logic                          hit_o
);
  // top bit of each alarm byte is the enable; never part of the value
  localparam logic [FIELD_W-1:0] VAL_MASK = {1'b0, {(FIELD_W-1){1'b1}}};

  logic [NUM_FIELDS-1:0] en;
  logic [NUM_FIELDS-1:0] eq;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_cmp
    assign en[k] = alm_i[k*FIELD_W + FIELD_W-1];
    assign eq[k] = ((alm_i[k*FIELD_W +: FIELD_W] ^ rtc_i[k*FIELD_W +: FIELD_W])
                    & VAL_MASK) == '0;
  end

  assign hit_o = (|en) & (&(~en | eq));
endmodule

// File: rtl/alarm_edge_flag.sv
module alarm_edge_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic prev_q;
  logic fire;

  assign fire = tick_i & hit_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      flag_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      if (tick_i) prev_q <= hit_i;
      pulse_o <= fire;
      flag_o  <= fire | (flag_o & ~clr_i);  // set wins over clear
    end
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp #(
  parameter int NUM_ALARMS = cal_alarm_pkg::NUM_ALARMS,
  parameter int NUM_FIELDS = cal_alarm_pkg::NUM_FIELDS,
  parameter int FIELD_W    = cal_alarm_pkg::FIELD_W,
  parameter int ALM_W      = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
  parameter int FLD_W      = $clog2(NUM_FIELDS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ALM_W-1:0]              wr_alarm_i,
  input  logic [FLD_W-1:0]              wr_field_i,
  input  logic [FIELD_W-1:0]            wr_data_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] rtc_fields_i,
  input  logic                          tick_i,
  input  logic [NUM_ALARMS-1:0]         flag_clr_i,
  output logic [NUM_ALARMS-1:0]         alarm_flag_o,
  output logic [NUM_ALARMS-1:0]         alarm_pulse_o
);
  localparam int BANK_W = NUM_FIELDS * FIELD_W;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alm
    logic              set_wr;
    logic [BANK_W-1:0] alm_bytes;
    logic              hit;

    assign set_wr = wr_en_i && (wr_alarm_i == ALM_W'(a));

    alarm_reg_bank #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .IDX_W(FLD_W)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (set_wr),
      .wr_idx_i (wr_field_i),
      .wr_data_i(wr_data_i),
      .bytes_o  (alm_bytes)
    );

    alarm_field_match #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)
    ) u_match (
      .alm_i(alm_bytes),
      .rtc_i(rtc_fields_i),
      .hit_o(hit)
    );

    alarm_edge_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .hit_i  (hit),
      .clr_i  (flag_clr_i[a]),
      .flag_o (alarm_flag_o[a]),
      .pulse_o(alarm_pulse_o[a])
    );
  end
endmodule

// File: rtl/cal_alarm_cmp_chk.sv
module cal_alarm_cmp_chk #(
  parameter int NUM_ALARMS = cal_alarm_pkg::NUM_ALARMS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [NUM_ALARMS-1:0] flag_clr_i,
  input logic [NUM_ALARMS-1:0] alarm_flag_o,
  input logic [NUM_ALARMS-1:0] alarm_pulse_o
);
  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
    a_r6_no_set_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !alarm_flag_o[a]) |=> !alarm_flag_o[a]);

    a_r8_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_flag_o[a] && !flag_clr_i[a]) |=> alarm_flag_o[a]);

    a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i[a] && !tick_i) |=> !alarm_flag_o[a]);

    a_r10_pulse_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_pulse_o[a] |-> alarm_flag_o[a]);

    a_r10_rise_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_flag_o[a]) |-> alarm_pulse_o[a]);

    a_r7_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_pulse_o[a] |=> !alarm_pulse_o[a]);
  end
endmodule

bind cal_alarm_cmp cal_alarm_cmp_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .flag_clr_i   (flag_clr_i),
  .alarm_flag_o (alarm_flag_o),
  .alarm_pulse_o(alarm_pulse_o)
);

// File: tb/tb_cal_alarm_cmp.sv
module tb_cal_alarm_cmp;
  localparam int NA = 2;
  localparam int NF = 6;
  localparam int RW = NF * 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [0:0]    wr_alarm = '0;
  logic [2:0]    wr_field = '0;
  logic [7:0]    wr_data = '0;
  logic [RW-1:0] rtc = '0;
  logic          tick = 1'b0;
  logic [NA-1:0] clr = '0;
  logic [NA-1:0] flag_o;
  logic [NA-1:0] pulse_o;

  always #5 clk = ~clk;

  cal_alarm_cmp dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_alarm_i(wr_alarm),
    .wr_field_i(wr_field), .wr_data_i(wr_data), .rtc_fields_i(rtc),
    .tick_i(tick), .flag_clr_i(clr), .alarm_flag_o(flag_o), .alarm_pulse_o(pulse_o)
  );

  typedef struct {
    logic [NA-1:0] flag;
    logic [NA-1:0] pulse;
    string         tag;
    int            due;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  logic [7:0]    m_reg [NA][NF];
  logic [NA-1:0] m_prev = '0;
  logic [NA-1:0] m_flag = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expected item one edge after it was driven
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (flag_o !== e.flag || pulse_o !== e.pulse) begin
        failures++;
        $display("FAIL %s: flag=%b pulse=%b expected flag=%b pulse=%b",
                 e.tag, flag_o, pulse_o, e.flag, e.pulse);
      end
    end
  end

  function automatic logic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [RW-1:0] mk(int s, int mi, int h, int d, int mo, int w);
    return {bcd(w), bcd(mo), bcd(d), bcd(h), bcd(mi), bcd(s)};
  endfunction

  function automatic logic model_hit(int a, logic [RW-1:0] r);
    logic any = 1'b0;
    logic ok  = 1'b1;
    for (int f = 0; f < NF; f++) begin
      if (m_reg[a][f][7]) begin
        any = 1'b1;
        if (m_reg[a][f][6:0] != r[f*8 +: 7]) ok = 1'b0;
      end
    end
    return any && ok;
  endfunction

  task automatic push(logic [NA-1:0] p, string tag);
    exp_t e;
    e.flag = m_flag; e.pulse = p; e.tag = tag; e.due = cyc + 1;
    sb_q.push_back(e);
  endtask

  task automatic step(logic [RW-1:0] r, logic tk, logic [NA-1:0] c, string tag);
    logic [NA-1:0] p;
    @(negedge clk);
    wr_en = 1'b0; rtc = r; tick = tk; clr = c;
    for (int a = 0; a < NA; a++) begin
      logic h;
      h = model_hit(a, r);
      p[a] = tk && h && !m_prev[a];
      m_flag[a] = p[a] | (m_flag[a] & ~c[a]);
      if (tk) m_prev[a] = h;
    end
    push(p, tag);
  endtask

  task automatic wr(int a, int f, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_alarm = 1'(a); wr_field = 3'(f); wr_data = d;
    tick = 1'b0; clr = '0;
    if (f < NF) m_reg[a][f] = d;
    push('0, "R2");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] r;
    for (int a = 0; a < NA; a++)
      for (int f = 0; f < NF; f++) m_reg[a][f] = 8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (flag_o !== '0 || pulse_o !== '0) begin
      failures++;
      $display("FAIL R1: flag=%b pulse=%b expected 00 00", flag_o, pulse_o);
    end
    rst_ni = 1'b1;

    // R1 / R5: all fields disabled at reset, zero clock must not fire
    step(mk(0, 0, 0, 0, 0, 0), 1'b1, '0, "R5");
    step(mk(0, 0, 0, 0, 0, 0), 1'b1, '0, "R1");
    // R2: unused field codes must not enable anything
    wr(0, 6, 8'h80);
    wr(0, 7, 8'h80);
    wr(1, 6, 8'h80);
    step(mk(0, 0, 0, 0, 0, 0), 1'b1, '0, "R2");
    step(mk(0, 1, 0, 0, 0, 0), 1'b1, '0, "R2");

    // R3 / R4: seconds-only alarm at :30 fires once per minute
    wr(0, 0, 8'hB0);
    for (int t = 0; t < 150; t++) begin
      r = mk(t % 60, t / 60, 9 + t / 60, 12, 5, 2);
      if ((t / 60) % 2 == 1) r[7] = 1'b1;  // clock bit 7 ignored
      step(r, 1'b1, '0, "R3");
      step(r, 1'b0, '0, "R6");
      if (t % 60 == 45) step(r, 1'b0, 2'b01, "R8");
    end

    // R7: frozen match fires once, even after clearing
    r = mk(30, 7, 9, 12, 5, 2);
    step(r, 1'b1, '0, "R7");
    step(r, 1'b1, '0, "R7");
    step(r, 1'b1, '0, "R7");
    step(r, 1'b0, 2'b01, "R8");
    step(r, 1'b1, '0, "R7");
    step(mk(31, 7, 9, 12, 5, 2), 1'b1, '0, "R7");
    step(r, 1'b1, '0, "R7");
    step(r, 1'b0, 2'b01, "R8");

    // R9 / R4: full six-field alarm on set 1
    wr(1, 0, 8'h80 | 8'h15);
    wr(1, 1, 8'h80 | 8'h42);
    wr(1, 2, 8'h80 | 8'h09);
    wr(1, 3, 8'h80 | 8'h21);
    wr(1, 4, 8'h80 | 8'h07);
    wr(1, 5, 8'h80 | 8'h03);
    step(mk(15, 42, 9, 21, 8, 3), 1'b1, '0, "R4");
    step(mk(15, 42, 9, 21, 7, 4), 1'b1, '0, "R4");
    step(mk(15, 43, 9, 21, 7, 3), 1'b1, '0, "R4");
    step(mk(15, 42, 9, 21, 7, 3), 1'b1, '0, "R9");
    step(mk(30, 42, 9, 21, 7, 3), 1'b1, '0, "R9");
    step(mk(31, 42, 9, 21, 7, 3), 1'b0, 2'b01, "R9");
    step(mk(31, 42, 9, 21, 7, 3), 1'b1, '0, "R8");
    step(mk(31, 42, 9, 21, 7, 3), 1'b0, 2'b10, "R9");

    // R8: fire and clear in the same cycle, set wins
    step(mk(15, 42, 9, 21, 7, 3), 1'b1, 2'b10, "R8");
    step(mk(16, 42, 9, 21, 7, 3), 1'b0, '0, "R8");
    step(mk(16, 42, 9, 21, 7, 3), 1'b1, 2'b11, "R8");

    // R5: set 1 with values that match but no enable never fires
    wr(1, 0, 8'h15);
    wr(1, 1, 8'h42);
    wr(1, 2, 8'h09);
    wr(1, 3, 8'h21);
    wr(1, 4, 8'h07);
    wr(1, 5, 8'h03);
    step(mk(14, 42, 9, 21, 7, 3), 1'b1, '0, "R5");
    step(mk(15, 42, 9, 21, 7, 3), 1'b1, '0, "R5");
    step(mk(15, 42, 9, 21, 7, 3), 1'b0, '0, "R5");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule